// File: doc/BRIEF.md
# Warp Memory Coalescing Unit

This block takes the load addresses of one warp and turns them into the fewest aligned memory transactions that cover them. Each of the 32 lanes supplies a byte address and an active bit, and each lane reads one 4-byte word. Lanes whose words fall in the same aligned 32-byte segment share a single transaction. The block emits the distinct segments one per cycle, lowest address first, on an output with a valid/ready handshake.

Alongside the request stream the block keeps three statistics for the warp. These are the number of transactions issued, the useful bytes (four per active lane) and the fetched bytes (32 per transaction). From them the caller can compute bandwidth efficiency. A one-cycle completion pulse marks the point where the statistics are final. A new warp is accepted only when the previous one has been fully issued.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `seg_valid`, `done` and all three statistics are 0, and `in_ready` is 1.
- R2: Thirty-two active lanes reading consecutive words from a 128-byte-aligned base produce exactly 4 segments: base, base+32, base+64 and base+96. Useful and fetched bytes are both 128.
- R3: Thirty-two active lanes reading every second word (a byte stride of 8) produce 8 segments, with 128 useful bytes and 256 fetched bytes.
- R4: A segment address is the lane address with its low 5 bits cleared. Lanes that share a segment cause that segment to be emitted once only.
- R5: Segments of one warp are emitted in strictly ascending address order, whatever the order of the lanes.
- R6: An inactive lane adds no segment and no useful bytes. A warp with no active lane completes with a `done` pulse, a transaction count of 0 and no segment emitted.
- R7: When `done` is high, `fetched_bytes` equals `txn_count` × 32. `useful_bytes` equals the number of active lanes × 4.
- R8: While `seg_valid` is high and `seg_ready` is low, the offered segment stays valid and `seg_addr` does not change.
- R9: `in_ready` is low from acceptance until completion. A request held on the input during that time does not change the warp in progress.
- R10: `seg_last` is high only with the final segment of a warp. `done` is high for exactly one cycle, the cycle after the final segment is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Warp request offered |
| in_ready | output | 1 | Block is idle and will accept a warp |
| in_addr | input | LANES*ADDR_W | Lane byte addresses, lane 0 in the low bits |
| in_active | input | LANES | Lane active bits, bit i for lane i |
| seg_valid | output | 1 | Segment request valid |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_addr | output | ADDR_W | Aligned segment byte address |
| seg_last | output | 1 | Final segment of the warp |
| done | output | 1 | One-cycle pulse: warp complete, statistics final |
| txn_count | output | $clog2(LANES+1) | Transactions issued for the warp |
| useful_bytes | output | $clog2(LANES*WORD_BYTES+1) | Bytes requested by active lanes |
| fetched_bytes | output | $clog2(LANES*SEG_BYTES+1) | Bytes moved by issued transactions |

## Verification
The bench runs warps that stress the merge: all lanes on one word, strided words, lanes listed in descending address order, and partly or fully inactive masks. A design that kept duplicate segments would report too many transactions. One that emitted segments in lane order would break the ascending sequence. One that counted inactive lanes would overstate useful bytes or issue stray segments, and an empty mask could hang it. Backpressure that alternates ready is applied to catch a segment that changes or is lost while stalled. A request held on the input during a run checks that a busy block ignores it.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic {
    WC_IDLE = 1'b0,
    WC_RUN  = 1'b1
  } wc_state_e;
endpackage

// File: rtl/wc_seg_min.sv
// Finds the lowest segment index among the pending lanes and marks every
// pending lane that maps to it.
module wc_seg_min #(
  parameter int LANES = 32,
  parameter int SEG_W = 27
) (
  input  logic [LANES*SEG_W-1:0] lane_seg,
  input  logic [LANES-1:0]       mask,
  output logic [SEG_W-1:0]       min_seg,
  output logic                   any,
  output logic [LANES-1:0]       match
);
  logic [SEG_W-1:0] seg_a [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_unpack
      assign seg_a[g] = lane_seg[g*SEG_W +: SEG_W];
      assign match[g] = mask[g] && (seg_a[g] == min_seg);
    end
  endgenerate

  always_comb begin
    min_seg = '1;
    any     = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (mask[i] && (!any || seg_a[i] < min_seg)) begin
        min_seg = seg_a[i];
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wc_popcount.sv
module wc_popcount #(
  parameter int N = 32,
  parameter int W = 6
) (
  input  logic [N-1:0] bits_in,
  output logic [W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + W'(bits_in[i]);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int SEG_BYTES  = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [LANES*ADDR_W-1:0]           in_addr,
  input  logic [LANES-1:0]                  in_active,
  output logic                              seg_valid,
  input  logic                              seg_ready,
  output logic [ADDR_W-1:0]                 seg_addr,
  output logic                              seg_last,
  output logic                              done,
  output logic [$clog2(LANES+1)-1:0]        txn_count,
  output logic [$clog2(LANES*WORD_BYTES+1)-1:0] useful_bytes,
  output logic [$clog2(LANES*SEG_BYTES+1)-1:0]  fetched_bytes
);
  import wc_pkg::*;

  localparam int SEG_SH = $clog2(SEG_BYTES);
  localparam int SEG_W  = ADDR_W - SEG_SH;
  localparam int TXN_W  = $clog2(LANES + 1);
  localparam int USE_W  = $clog2(LANES * WORD_BYTES + 1);
  localparam int FET_W  = $clog2(LANES * SEG_BYTES + 1);
  localparam int WB_SH  = $clog2(WORD_BYTES);

  wc_state_e          state;
  logic [LANES-1:0]   pending;
  logic [LANES*SEG_W-1:0] seg_store;
  logic [SEG_W-1:0]   min_seg;
  logic               any;
  logic [LANES-1:0]   match;
  logic [TXN_W-1:0]   act_cnt;
  logic               accept, take, load, finish;

  wc_seg_min #(.LANES(LANES), .SEG_W(SEG_W)) u_min (
    .lane_seg(seg_store), .mask(pending),
    .min_seg(min_seg), .any(any), .match(match)
  );

  wc_popcount #(.N(LANES), .W(TXN_W)) u_pop (
    .bits_in(in_active), .count(act_cnt)
  );

  assign in_ready = (state == WC_IDLE);
  assign accept   = in_valid && in_ready;
  assign take     = seg_valid && seg_ready;
  assign load     = (state == WC_RUN) && any && (!seg_valid || take);
  assign finish   = (state == WC_RUN) &&
                    ((take && seg_last) || (!seg_valid && !any));

  // Segment index store: written once per warp, no reset needed.
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_store
      always_ff @(posedge clk) begin
        if (accept)
          seg_store[g*SEG_W +: SEG_W] <= in_addr[g*ADDR_W + SEG_SH +: SEG_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= WC_IDLE;
      pending       <= '0;
      seg_valid     <= 1'b0;
      seg_addr      <= '0;
      seg_last      <= 1'b0;
      done          <= 1'b0;
      txn_count     <= '0;
      useful_bytes  <= '0;
      fetched_bytes <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        state         <= WC_RUN;
        pending       <= in_active;
        txn_count     <= '0;
        useful_bytes  <= USE_W'(act_cnt) << WB_SH;
        fetched_bytes <= '0;
      end
      if (load) begin
        seg_valid     <= 1'b1;
        seg_addr      <= {min_seg, {SEG_SH{1'b0}}};
        seg_last      <= ((pending & ~match) == '0);
        pending       <= pending & ~match;
        txn_count     <= txn_count + 1'b1;
        fetched_bytes <= fetched_bytes + FET_W'(SEG_BYTES);
      end else if (take) begin
        seg_valid <= 1'b0;
        seg_last  <= 1'b0;
      end
      if (finish) state <= WC_IDLE;
    end
  end

  // R8: a stalled segment is held unchanged
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr)));

  // R5: each following segment of a warp has a higher address
  a_r5_ascending: assert property (@(posedge clk) disable iff (rst)
    (take && !seg_last) |=> (seg_valid && seg_addr > $past(seg_addr)));

  // R7: fetched bytes track the transaction count at completion
  a_r7_fetched: assert property (@(posedge clk) disable iff (rst)
    done |-> (fetched_bytes == (FET_W'(txn_count) << SEG_SH)));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: no new warp is accepted while a segment is outstanding
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> !in_ready);

  // R4: every load retires at least one pending lane
  a_r4_progress: assert property (@(posedge clk) disable iff (rst)
    load |=> ($countones(pending) < $countones($past(pending))));
endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0] in_active = '0;
  logic seg_valid, seg_ready = 1'b0, seg_last, done;
  logic [AW-1:0] seg_addr;
  logic [5:0]  txn_count;
  logic [7:0]  useful_bytes;
  logic [10:0] fetched_bytes;

  int errors = 0;
  int checks = 0;

  logic [AW-1:0] lane_a [LANES];
  logic [LANES-1:0] lane_m;
  logic [AW-1:0] got_a [LANES+1];
  logic          got_l [LANES+1];
  int n_got;

  always #2.5 clk = ~clk;

  warp_coalescer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_active(in_active), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_last(seg_last),
    .done(done), .txn_count(txn_count), .useful_bytes(useful_bytes),
    .fetched_bytes(fetched_bytes)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs the warp in lane_a/lane_m. rmode 1 alternates seg_ready.
  // hold keeps a junk request on the input while busy.
  task automatic run_warp(input int rmode, input bit hold);
    logic [AW-1:0] stall_a;
    bit stalled;
    int cyc;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) in_addr[i*AW +: AW] = lane_a[i];
    in_active = lane_m;
    in_valid  = 1'b1;
    @(negedge clk);
    if (hold) begin
      in_addr   = ~in_addr;
      in_active = '1;
    end else in_valid = 1'b0;
    n_got = 0; stalled = 0; cyc = 0;
    forever begin
      seg_ready = (rmode == 1) ? cyc[0] : 1'b1;
      if (stalled) begin
        chk("R8", "stalled valid", {31'd0, seg_valid}, 1);
        chk("R8", "stalled addr", seg_addr, stall_a);
      end
      stalled = 0;
      if (seg_valid) chk("R9", "in_ready busy", {31'd0, in_ready}, 0);
      if (seg_valid && seg_ready && n_got <= LANES) begin
        got_a[n_got] = seg_addr; got_l[n_got] = seg_last; n_got++;
      end else if (seg_valid) begin
        stalled = 1; stall_a = seg_addr;
      end
      if (done) break;
      @(negedge clk);
      cyc++;
    end
    in_valid  = 1'b0;
    seg_ready = 1'b0;
  endtask

  // Bench model: sorted unique segments and statistics.
  task automatic expect_warp(input string req);
    logic [AW-1:0] ex [LANES];
    logic [AW-1:0] t;
    int n = 0;
    int act = 0;
    bit dup;
    for (int i = 0; i < LANES; i++) begin
      if (lane_m[i]) begin
        act++;
        t = {lane_a[i][AW-1:5], 5'd0};
        dup = 0;
        for (int k = 0; k < n; k++) if (ex[k] == t) dup = 1;
        if (!dup) begin ex[n] = t; n++; end
      end
    end
    for (int a = 0; a < n; a++)
      for (int b = 0; b + 1 < n - a; b++)
        if (ex[b] > ex[b+1]) begin t = ex[b]; ex[b] = ex[b+1]; ex[b+1] = t; end
    chk(req, "segment count", n_got, n);
    chk(req, "txn_count", {26'd0, txn_count}, n);
    chk("R7", "useful_bytes", {24'd0, useful_bytes}, act * 4);
    chk("R7", "fetched_bytes", {21'd0, fetched_bytes}, n * 32);
    for (int k = 0; k < n && k < n_got; k++) begin
      chk(req, "segment addr (R5 order)", got_a[k], ex[k]);
      chk("R10", "seg_last", {31'd0, got_l[k]}, (k == n - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R10", "done single cycle", {31'd0, done}, 0);
    chk("R9", "in_ready after done", {31'd0, in_ready}, 1);
  endtask

  task automatic t_reset;
    chk("R1", "seg_valid", {31'd0, seg_valid}, 0);
    chk("R1", "done", {31'd0, done}, 0);
    chk("R1", "in_ready", {31'd0, in_ready}, 1);
    chk("R1", "txn_count", {26'd0, txn_count}, 0);
    chk("R1", "fetched", {21'd0, fetched_bytes}, 0);
    chk("R1", "useful", {24'd0, useful_bytes}, 0);
  endtask

  task automatic t_contig;  // R2
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h1000 + 4 * i;
    lane_m = '1;
    run_warp(0, 0);
    expect_warp("R2");
    chk("R2", "third segment", got_a[2], 32'h1040);
  endtask

  task automatic t_stride2;  // R3
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h2000 + 8 * i;
    lane_m = '1;
    run_warp(0, 0);
    expect_warp("R3");
    chk("R3", "fetched 256", {21'd0, fetched_bytes}, 256);
  endtask

  task automatic t_dup;  // R4
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h3004 + (i % 2) * 8;
    lane_m = '1;
    run_warp(0, 0);
    expect_warp("R4");
    chk("R4", "single segment addr", got_a[0], 32'h3000);
  endtask

  task automatic t_reverse;  // R5
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h4000 + 32 * (LANES - 1 - i) + 4;
    lane_m = '1;
    run_warp(0, 0);
    expect_warp("R5");
  endtask

  task automatic t_inactive;  // R6
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h5000 + 4 * i;
    lane_m = 32'h0000_FFFF;
    run_warp(0, 0);
    expect_warp("R6");
    lane_m = 32'h0000_0000;
    run_warp(0, 0);
    expect_warp("R6");
    chk("R6", "empty warp segments", n_got, 0);
  endtask

  task automatic t_backpressure;  // R8
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h6000 + 8 * i;
    lane_m = 32'hA5A5_F00F;
    run_warp(1, 0);
    expect_warp("R8");
  endtask

  task automatic t_busy;  // R9
    for (int i = 0; i < LANES; i++) lane_a[i] = 32'h7000 + 4 * i;
    lane_m = '1;
    run_warp(0, 1);
    expect_warp("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_contig();
    t_stride2();
    t_dup();
    t_reverse();
    t_inactive();
    t_backpressure();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule